// File: doc/BRIEF.md
# Serial All-Zero Code Detector

This block watches one serial ADPCM input stream that carries a four-bit code word in every 8 kHz frame. A frame starts at the rising edge of a frame-sync input; the code bits follow one per bit-clock edge, most significant bit first. When all four bits of a frame are zero, the block raises a registered flag. It updates the flag once per frame, at the bit-clock edge that takes in the last code bit, and holds the value until the next frame completes. Consecutive all-zero frames keep the flag high with no gap. The block does not decode the code word.

A pass-through control input forces the flag low while it is high. In that mode the stream does not carry ADPCM codes, so a zero nibble means nothing. A frame that is cut short, because a new sync edge arrives before four bits are in, is dropped and leaves the flag as it was. Bits that arrive after the fourth bit and before the next sync edge are ignored.

A small state machine sequences the frame. Its states are ST_WAIT (after reset, no frame seen yet), ST_GATHER (code bits being taken in) and ST_HOLD (frame complete, extra bits ignored). It has these transitions:
- A sync rising edge moves any state to ST_GATHER.
- ST_GATHER moves to ST_HOLD on the edge that takes in the last bit.
- ST_WAIT and ST_HOLD otherwise stay where they are.
- A cut-short frame is a sync rising edge that arrives while the machine is still in ST_GATHER.

Top module: `zero_nibble_detector`

## Requirements
- R1: A synchronous active-low reset sets `zero_flag` to 0, and the flag stays 0 until a complete all-zero frame has been taken in.
- R2: A frame starts at the first `bclk` rising edge where `frame_sync` is sampled 1 after being sampled 0. The code's most significant bit is sampled on that same edge, and the remaining three bits on the next three edges, in falling bit order.
- R3: When the four code bits of a frame are all 0, `zero_flag` is 1 right after the edge that samples the fourth bit.
- R4: When any of the four code bits is 1, including only the first or only the last, `zero_flag` is 0 right after the edge that samples the fourth bit.
- R5: `zero_flag` changes only at a frame's fourth-bit edge or under pass-through. Across back-to-back all-zero frames it stays 1 on every cycle.
- R6: Bits sampled after a frame's fourth bit and before the next sync rising edge have no effect on `zero_flag`.
- R7: If a sync rising edge arrives before a frame's fourth bit, that frame is dropped, `zero_flag` keeps its value, and a new frame starts at that edge.
- R8: While `thru_en` is sampled 1, `zero_flag` is 0 after that edge, and frames that complete during that time do not set it. After `thru_en` returns to 0, the flag stays 0 until the next frame completes.
- R9: Holding `frame_sync` at 1 for several edges counts as one frame start. The code bits are still sampled on the edges that follow, regardless of the sync level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | Frame sync; its rising edge marks the code MSB |
| ser_in | input | 1 | Serial code bits, MSB first |
| thru_en | input | 1 | Pass-through mode; forces the flag low |
| zero_flag | output | 1 | High after a frame whose four code bits were all zero |

## Verification
A wrong bit count or a missed sync edge puts the fourth-bit edge at the wrong place. The flag then moves one or more cycles early or late, or reflects a nibble that includes a bit from before the frame or from its tail, and this shows within the same frame. A shift register that drops the first or last bit shows at the next frame whose only 1 sits in that position. A stale pass-through clear shows as the flag rising during a zero frame in that mode. The bench compares the flag against an independent frame model on every cycle, so each of these errors shows within one frame of the fault.

// File: rtl/zdet_pkg.sv
package zdet_pkg;

    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_GATHER = 2'd1,
        ST_HOLD   = 2'd2
    } zdet_state_e;

endpackage

// File: rtl/zdet_edge.sv
module zdet_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic sync_rise
);

    logic sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync_in;
    end

    assign sync_rise = sync_in & ~sync_q;

    // R9
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rise |=> !sync_rise);

endmodule

// File: rtl/zdet_shift.sv
module zdet_shift #(
    parameter int CODE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic ser_bit,
    output logic word_zero
);

    localparam int HELD_W = CODE_W - 1;

    logic [HELD_W-1:0] held;
    logic [CODE_W-1:0] word_next;

    assign word_next = {held, ser_bit};
    assign word_zero = (word_next == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)        held <= '0;
        else if (shift_en) held <= word_next[HELD_W-1:0];
    end

endmodule

// File: rtl/zdet_ctrl.sv
module zdet_ctrl
    import zdet_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_rise,
    input  logic thru,
    input  logic word_zero,
    output logic shift_en,
    output logic flag
);

    localparam int CW = (CODE_W > 2) ? $clog2(CODE_W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(CODE_W - 1);
    localparam logic [CW-1:0] ONE      = CW'(1);

    zdet_state_e      state, nxt;
    logic [CW-1:0]    cnt;
    logic             last_bit;

    // next state and shift control
    always_comb begin
        nxt      = state;
        shift_en = 1'b0;
        last_bit = 1'b0;
        if (sync_rise) begin
            nxt      = ST_GATHER;
            shift_en = 1'b1;
        end else begin
            unique case (state)
                ST_WAIT:   nxt = ST_WAIT;
                ST_GATHER: begin
                    shift_en = 1'b1;
                    if (cnt == LAST_IDX) begin
                        last_bit = 1'b1;
                        nxt      = ST_HOLD;
                    end
                end
                ST_HOLD:   nxt = ST_HOLD;
                default:   nxt = ST_WAIT;
            endcase
        end
    end

    // state register and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAIT;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (sync_rise)               cnt <= ONE;
            else if (state == ST_GATHER) cnt <= cnt + ONE;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (thru)     flag <= 1'b0;
        else if (last_bit) flag <= word_zero;
    end

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!last_bit && !thru) |=> $stable(flag));

    // R8
    thru_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thru |=> !flag);

    // R2
    frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rise |=> (state == ST_GATHER) && (cnt == ONE));

    // R6
    hold_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !sync_rise) |=> (state == ST_HOLD));

    // R3
    zero_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && !thru && word_zero) |=> flag);

    // R7
    cut_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GATHER && sync_rise && !thru) |=> $stable(flag));

endmodule

// File: rtl/zero_nibble_detector.sv
module zero_nibble_detector #(
    parameter int CODE_W = 4
) (
    input  logic bclk,
    input  logic rst_n,
    input  logic frame_sync,
    input  logic ser_in,
    input  logic thru_en,
    output logic zero_flag
);

    logic sync_rise;
    logic shift_en;
    logic word_zero;

    zdet_edge u_edge (
        .clk       (bclk),
        .rst_n     (rst_n),
        .sync_in   (frame_sync),
        .sync_rise (sync_rise)
    );

    zdet_shift #(.CODE_W(CODE_W)) u_shift (
        .clk       (bclk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .ser_bit   (ser_in),
        .word_zero (word_zero)
    );

    zdet_ctrl #(.CODE_W(CODE_W)) u_ctrl (
        .clk       (bclk),
        .rst_n     (rst_n),
        .sync_rise (sync_rise),
        .thru      (thru_en),
        .word_zero (word_zero),
        .shift_en  (shift_en),
        .flag      (zero_flag)
    );

endmodule

// File: tb/zero_nibble_detector_tb.sv
module zero_nibble_detector_tb;

    logic bclk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_sync = 1'b0;
    logic ser_in = 1'b0;
    logic thru_en = 1'b0;
    logic zero_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference frame model
    bit       m_prev_sync = 0;
    bit       m_active    = 0;
    int       m_cnt       = 0;
    bit [3:0] m_acc       = 4'h0;
    bit       m_flag      = 0;

    always #4 bclk = ~bclk;

    zero_nibble_detector u_dut (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .ser_in     (ser_in),
        .thru_en    (thru_en),
        .zero_flag  (zero_flag)
    );

    function automatic void model_edge(bit rst, bit sy, bit sd, bit th);
        bit rise;
        if (!rst) begin
            m_prev_sync = 0; m_active = 0; m_cnt = 0; m_acc = 0; m_flag = 0;
            return;
        end
        rise = sy && !m_prev_sync;
        m_prev_sync = sy;
        if (rise) begin
            m_active = 1; m_cnt = 1; m_acc = {3'b000, sd};
        end else if (m_active) begin
            m_acc = {m_acc[2:0], sd};
            m_cnt++;
            if (m_cnt == 4) begin
                m_active = 0;
                m_flag = (m_acc == 4'h0);
            end
        end
        if (th) m_flag = 0;
    endfunction

    task automatic check(string tag);
        checks++;
        if (zero_flag !== m_flag) begin
            fails++;
            $display("FAIL %s: zero_flag=%0b expected=%0b at %0t", tag, zero_flag, m_flag, $time);
        end
    endtask

    // inputs set at negedge, edge taken, output checked at next negedge
    task automatic step(bit sy, bit sd, bit th, string tag);
        frame_sync = sy; ser_in = sd; thru_en = th;
        @(posedge bclk);
        model_edge(rst_n, sy, sd, th);
        @(negedge bclk);
        check(tag);
    endtask

    task automatic frame(bit [3:0] code, int nbits, int synclen, int tail,
                         bit [3:0] tailbits, bit th, string tag);
        for (int i = 0; i < nbits; i++)
            step(i < synclen, code[3-i], th, tag);
        for (int j = 0; j < tail; j++)
            step(0, tailbits[j%4], th, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        @(negedge bclk);
        // R1: reset holds flag low
        step(1, 0, 0, "R1 in reset");
        step(0, 0, 0, "R1 in reset");
        rst_n = 1'b1;
        step(0, 0, 0, "R1 after reset");
        step(0, 1, 0, "R1 idle");
        // R2 R3: all-zero frame sets flag
        frame(4'h0, 4, 1, 3, 4'hF, 0, "R3 zero frame");
        // R5 R9: back-to-back zero frames, sync held long
        frame(4'h0, 4, 3, 1, 4'h0, 0, "R5 R9 zero frame long sync");
        frame(4'h0, 4, 2, 1, 4'h0, 0, "R5 consecutive zero");
        // R4: only LSB set
        frame(4'h1, 4, 1, 2, 4'h0, 0, "R4 lsb only");
        frame(4'h0, 4, 1, 2, 4'h0, 0, "R3 zero again");
        // R4 R2: only MSB set
        frame(4'h8, 4, 1, 2, 4'h0, 0, "R4 R2 msb only");
        // R6: nonzero tail after zero frame
        frame(4'h0, 4, 1, 6, 4'hF, 0, "R6 tail ignored");
        // R7: cut-short frame with nonzero bits
        frame(4'hF, 2, 1, 0, 4'h0, 0, "R7 short frame");
        step(0, 0, 0, "R7 short frame gap");
        frame(4'h0, 3, 1, 0, 4'h0, 0, "R7 short zero");
        frame(4'h6, 4, 1, 1, 4'h0, 0, "R7 new frame");
        frame(4'h0, 2, 1, 0, 4'h0, 0, "R7 short zero keeps 0");
        step(0, 0, 0, "R7 gap");
        frame(4'h0, 4, 1, 1, 4'h0, 0, "R3 zero frame");
        // R8: pass-through forces flag low
        frame(4'h0, 4, 1, 2, 4'h0, 1, "R8 thru zero frame");
        frame(4'h0, 2, 1, 0, 4'h0, 0, "R8 after thru partial");
        step(0, 0, 0, "R8 after thru");
        step(0, 0, 0, "R8 after thru");
        frame(4'h0, 4, 1, 1, 4'h0, 0, "R8 first frame after thru");
        // random mix
        for (int k = 0; k < 400; k++) begin
            bit [3:0] c;
            int nb, sl, tl;
            bit th;
            c  = ($urandom % 3 == 0) ? 4'h0 : 4'($urandom);
            nb = ($urandom % 8 == 0) ? int'($urandom % 4) + 1 : 4;
            sl = int'($urandom % 3) + 1;
            if (sl > nb) sl = nb;
            tl = int'($urandom % 5) + ((sl == nb) ? 1 : 0);
            th = ($urandom % 10 == 0);
            frame(c, nb, sl, tl, 4'($urandom), th, "R3 R4 R6 R7 R8 random");
        end
        // R1: reset mid-run
        rst_n = 1'b0;
        step(0, 0, 0, "R1 reset again");
        rst_n = 1'b1;
        step(0, 0, 0, "R1 after reset");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule